// File: doc/BRIEF.md
# Huffman Tree-Walking Stream Decoder

The block turns a stream of Huffman-coded bits back into 8-bit characters. It walks a binary code tree that is held in a 512-entry on-chip node memory. Software, or a loader ahead of the block, fills that memory through a simple write port and supplies the root address as a configuration input. A start pulse then begins a decode session. Each node word is a tagged union. A branch node is steered left or right by the next input bit. A leaf node yields a character, and the walk then returns to the root without consuming a bit.

Coded bits enter on a valid/ready stream. A beat whose `in_last` is high carries no bit and marks the end of the stream. A beat transfers on a clock edge where `in_valid` and `in_ready` are both high. The sender must hold a beat stable until it transfers. `in_ready` never depends on `in_valid`. Characters leave on a valid/ready stream. Once `out_valid` rises, `out_char` stays stable until the edge where `out_ready` is high. While a character waits, the walk is frozen: no node is fetched and no input bit is taken. Node reads have one cycle of latency, so each consumed bit costs at least two cycles.

Top module: `huff_walk_decoder`

## Requirements
- R1: After reset, `in_ready`, `out_valid`, `done` and `err` are all 0.
- R2: A cycle with `tw_en` high writes `tw_data` into node `tw_addr`. A node is 19 bits wide. Bit 18 is the tag. When the tag is 1 the node is a leaf, and bits 7:0 hold its character. When the tag is 0 the node is a branch, with the left child address in bits 17:9 and the right child address in bits 8:0.
- R3: At a branch, an accepted beat with `in_last`=0 consumes `in_bit`. A 0 moves the walk to the left child and a 1 moves it to the right child.
- R4: On reaching a leaf, the block offers the leaf's character on `out_char`. After that character is taken, the walk restarts at `cfg_root`, and no input bit is consumed for the restart.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_char` holds its value, and `in_ready` stays low.
- R6: An end-of-stream beat accepted at the root, between codes, raises `done` with `err`=0. All complete codes are emitted before it.
- R7: An end-of-stream beat accepted partway into a code raises `done` with `err`=1, and no character is emitted for the partial code.
- R8: A `start` pulse is honoured only while idle or done. It clears `done` and `err` and begins at the current `cfg_root`. While idle or done, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a decode session |
| cfg_root | input | 9 | Address of the tree root node |
| tw_en | input | 1 | Node memory write enable |
| tw_addr | input | 9 | Node memory write address |
| tw_data | input | 19 | Node word to write |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Decoder can take an input beat |
| in_bit | input | 1 | Coded bit (0 left, 1 right) |
| in_last | input | 1 | Beat is the end-of-stream marker, carries no bit |
| out_valid | output | 1 | Decoded character valid |
| out_ready | input | 1 | Consumer takes the character |
| out_char | output | 8 | Decoded character |
| done | output | 1 | Session finished |
| err | output | 1 | Stream ended inside a code (valid with done) |

## Verification
Random strings are encoded against two trees. One is deeply skewed, with codes up to five bits long. The other is a balanced tree at a different root. Random gaps on the input side and random back-pressure on the output side run throughout. The decoded text must match exactly. A design that consumed a bit on leaf restart, or that did not return to the root, would drift out of step and garble everything that follows the first leaf. Stall cycles check that the character holds and that no input is taken; a walk that kept fetching would reorder or drop characters. A stream cut off after two bits of a code must end with the error flag set and no output, while a clean end must not set the flag. A second session checks that `start` clears that flag.

// File: rtl/huff_pkg.sv
package huff_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_EMIT,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/huff_node_ram.sv
module huff_node_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  // read word is held while the walk waits on a decision
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !$past(rd_en)) |=> $stable(rd_data)); // R3
endmodule

// File: rtl/huff_walk_ctrl.sv
module huff_walk_ctrl
  import huff_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int CHAR_W = 8,
  localparam int NODE_W = 1 + 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_root,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [NODE_W-1:0] rd_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              done,
  output logic              err
);
  walk_state_t       state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [CHAR_W-1:0] char_q;
  logic              mid_q;
  logic              err_q;

  logic              node_leaf;
  logic [ADDR_W-1:0] left_ptr;
  logic [ADDR_W-1:0] right_ptr;
  logic              beat;

  always_comb begin
    node_leaf = rd_data[NODE_W-1];
    left_ptr  = rd_data[NODE_W-2 -: ADDR_W];
    right_ptr = rd_data[ADDR_W-1:0];
    rd_en     = (state_q == ST_FETCH);
    rd_addr   = cur_q;
    in_ready  = (state_q == ST_DECIDE) && !node_leaf;
    beat      = in_ready && in_valid;
    out_valid = (state_q == ST_EMIT);
    out_char  = char_q;
    done      = (state_q == ST_DONE);
    err       = err_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      char_q  <= '0;
      mid_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state_q <= ST_FETCH;
            cur_q   <= cfg_root;
            mid_q   <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        ST_FETCH: state_q <= ST_DECIDE;
        ST_DECIDE: begin
          if (node_leaf) begin
            char_q  <= rd_data[CHAR_W-1:0];
            mid_q   <= 1'b0;
            state_q <= ST_EMIT;
          end else if (beat) begin
            if (in_last) begin
              err_q   <= mid_q;
              state_q <= ST_DONE;
            end else begin
              cur_q   <= in_bit ? right_ptr : left_ptr;
              mid_q   <= 1'b1;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            cur_q   <= cfg_root;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char))); // R5
  AST_NO_INPUT_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R5
  AST_ROOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (rd_en && rd_addr == $past(cfg_root))); // R4
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!in_ready && !out_valid)); // R8
  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7
endmodule

// File: rtl/huff_walk_decoder.sv
module huff_walk_decoder #(
  parameter int ADDR_W = 9,
  parameter int CHAR_W = 8,
  localparam int NODE_W = 1 + 2 * ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_root,
  input  logic              tw_en,
  input  logic [ADDR_W-1:0] tw_addr,
  input  logic [NODE_W-1:0] tw_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_char,
  output logic              done,
  output logic              err
);
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [NODE_W-1:0] rd_data;

  huff_node_ram #(.ADDR_W(ADDR_W), .DATA_W(NODE_W)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tw_en), .wr_addr(tw_addr), .wr_data(tw_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  huff_walk_ctrl #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_root(cfg_root),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char),
    .done(done), .err(err)
  );
endmodule

// File: tb/huff_walk_decoder_tb.sv
`timescale 1ns/1ps
module huff_walk_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  cfg_root = '0;
  logic        tw_en = 1'b0;
  logic [8:0]  tw_addr = '0;
  logic [18:0] tw_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_bit = 1'b0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_char;
  logic        done;
  logic        err;

  int checks = 0;
  int fails  = 0;
  int hs_cnt = 0;
  logic [7:0] exp_q [64];
  int         sym_q [64];
  int         n_syms;
  int         tree_sel;

  always #5 clk = ~clk;

  huff_walk_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_root(cfg_root),
    .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_char(out_char),
    .done(done), .err(err)
  );

  always @(posedge clk) if (out_valid && out_ready) hs_cnt <= hs_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_branch(input int l, input int r);
    return {1'b0, 9'(l), 9'(r)};
  endfunction
  function automatic logic [18:0] mk_leaf(input logic [7:0] c);
    return {1'b1, 10'd0, c};
  endfunction
  function automatic logic [7:0] sym_char(input int t, input int s);
    return (t == 0) ? 8'(8'h41 + s) : 8'(8'h57 + s);
  endfunction
  function automatic int code_len(input int t, input int s);
    if (t == 1) return 2;
    return (s == 5) ? 5 : s + 1;
  endfunction
  function automatic bit code_bit(input int t, input int s, input int k);
    if (t == 1) return (k == 0) ? s[1] : s[0];
    return (k < s) ? 1'b1 : (s == 5);
  endfunction

  task automatic wr(input int a, input logic [18:0] d);
    @(posedge clk); #1;
    tw_en = 1'b1; tw_addr = 9'(a); tw_data = d;
    @(posedge clk); #1;
    tw_en = 1'b0;
  endtask

  task automatic push_beat(input bit b, input bit last);
    repeat ($urandom % 3) @(posedge clk);
    #1;
    in_valid = 1'b1; in_bit = b; in_last = last;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic feeder();
    for (int i = 0; i < n_syms; i++)
      for (int k = 0; k < code_len(tree_sel, sym_q[i]); k++)
        push_beat(code_bit(tree_sel, sym_q[i], k), 1'b0);
    push_beat(1'b0, 1'b1);
  endtask

  task automatic collector();
    int   got = 0;
    bit   stalled = 0;
    logic [7:0] held = '0;
    while (got < n_syms) begin
      @(negedge clk);
      if (stalled) begin
        chk(out_valid === 1'b1 && out_char === held, "R5 hold", int'(out_char), int'(held));
        chk(in_ready === 1'b0, "R5 no input during stall", int'(in_ready), 0);
      end
      out_ready = ($urandom % 4) != 0;
      stalled = out_valid && !out_ready;
      held = out_char;
      if (out_valid && out_ready) begin
        chk(out_char === exp_q[got], "R3 R4 decoded char", int'(out_char), int'(exp_q[got]));
        got++;
      end
    end
    @(negedge clk); out_ready = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_start(input int root);
    @(posedge clk); #1;
    cfg_root = 9'(root); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_session(input int t, input int root, input int n);
    tree_sel = t; n_syms = n;
    for (int i = 0; i < n; i++) begin
      sym_q[i] = (t == 0) ? int'($urandom % 6) : int'($urandom % 4);
      exp_q[i] = sym_char(t, sym_q[i]);
    end
    if (t == 0) sym_q[0] = 5;  // deepest code first
    exp_q[0] = sym_char(t, sym_q[0]);
    pulse_start(root);
    fork feeder(); collector(); join
    wait_done();
    @(negedge clk);
    chk(done === 1'b1, "R6 done at clean end", int'(done), 1);
    chk(err === 1'b0, "R6 no error at clean end", int'(err), 0);
    chk(out_valid === 1'b0, "R6 no extra char", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready === 1'b0 && out_valid === 1'b0, "R1 reset handshakes", int'({in_ready, out_valid}), 0);
    chk(done === 1'b0 && err === 1'b0, "R1 reset flags", int'({done, err}), 0);
    rst_n = 1'b1;
    // skewed tree, root 100: branch i -> leaf i on the left, next branch on the right
    for (int i = 0; i < 5; i++)
      wr(100 + 37 * i, mk_branch(300 + 5 * i, (i == 4) ? 325 : 100 + 37 * (i + 1)));
    for (int i = 0; i < 6; i++) wr(300 + 5 * i, mk_leaf(sym_char(0, i)));
    // balanced tree, root 400
    wr(400, mk_branch(401, 402));
    wr(401, mk_branch(410, 411));
    wr(402, mk_branch(412, 413));
    for (int i = 0; i < 4; i++) wr(410 + i, mk_leaf(sym_char(1, i)));
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b0, "R8 idle takes no input", int'(in_ready), 0);

    run_session(0, 100, 40);   // R2 R3 R4 R5 R6

    // R7: stream cut after two bits of a code
    begin
      int hs0;
      hs0 = hs_cnt;
      tree_sel = 0;
      pulse_start(100);
      push_beat(1'b1, 1'b0);
      push_beat(1'b1, 1'b0);
      push_beat(1'b0, 1'b1);
      wait_done();
      @(negedge clk);
      chk(done === 1'b1, "R7 done on partial code", int'(done), 1);
      chk(err === 1'b1, "R7 error on partial code", int'(err), 1);
      chk(hs_cnt == hs0, "R7 no char for partial code", hs_cnt - hs0, 0);
      repeat (3) @(negedge clk);
      chk(in_ready === 1'b0 && err === 1'b1, "R8 done holds, no input", int'({in_ready, err}), 1);
    end

    // R8: restart on another root clears the error
    pulse_start(400);
    @(negedge clk);
    chk(done === 1'b0 && err === 1'b0, "R8 start clears flags", int'({done, err}), 0);
    in_valid = 1'b1; in_last = 1'b1;  // immediate end at root
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1; in_valid = 1'b0; in_last = 1'b0;
    wait_done(); @(negedge clk);
    chk(done === 1'b1 && err === 1'b0, "R6 empty stream clean end", int'({done, err}), 2);

    run_session(1, 400, 30);   // R8 new root honoured
    run_session(0, 100, 25);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule